// File: doc/BRIEF.md
# Compare-Match Global Timer

This peripheral keeps a 64-bit up-counter that never reloads and is advanced by an 8-bit clock divider. A 64-bit match register is compared against the counter. When the counter first reaches or passes the match value, a sticky status bit is set. In periodic mode the match value is also moved forward by a 32-bit step, so the next event follows one step later. With the step feature off, the timer fires once. The status bit drives a level interrupt output when the interrupt is enabled. Software clears the status bit by writing a one to it.

Software uses a simple single-cycle 32-bit register bus. A write is taken on the clock edge where `bus_wen` is high. Read data is combinational from `bus_addr`. Every access is a full word. To read the 64-bit counter consistently, software reads the high word, then the low word, then the high word again, and retries if the two high-word reads differ.

Register map (word addresses):

| Address | Register |
|---|---|
| 0 | counter low |
| 1 | counter high |
| 2 | control |
| 3 | status |
| 4 | match low |
| 5 | match high |
| 6 | step |
| 7 | unused |

Control register bits:

| Bit(s) | Function |
|---|---|
| 0 | run |
| 1 | compare enable |
| 2 | interrupt enable |
| 3 | periodic |
| 15:8 | divider |

Top module: `gtimer_cmp`

## Requirements
- R1: After reset every register reads zero and `irq` is low. The reset input is asynchronous, and its release is synchronised to `clk` through two flops.
- R2: While run (control bit 0) is set, the counter advances by one every (divider + 1) clocks, where the divider is control bits 15:8. While run is clear, the counter holds and the divider phase restarts from zero.
- R3: Address 0 reads and writes counter bits 31:0, and address 1 reads and writes counter bits 63:32. A carry from the low word reaches the high word. A write to either counter word replaces that word and cancels that cycle's advance.
- R4: The control register reads back bits 3:0 and 15:8 as written. All other control bits read as zero.
- R5: When compare enable (bit 1) is set and the counter is greater than or equal to the match value, a match event occurs, and status bit 0 is set on the next edge.
- R6: With periodic (bit 3) clear, a match event fires once. No further event occurs until a match word is written or compare enable is cleared.
- R7: With periodic set, each match event adds the zero-extended step register (address 6) to the match value, and the detector stays armed.
- R8: With compare enable clear, there are no match events, the match value does not change and status stays clear, while the counter keeps running.
- R9: Status bit 0 is sticky. Writing 1 to address 3 clears it, and writing 0 has no effect. If a match event and a clear fall in the same cycle, the bit ends up set.
- R10: `irq` is high exactly when status bit 0 and interrupt enable (bit 2) are both set.
- R11: Address 7 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | AW (3) | Word address |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Combinational read data |
| irq | output | 1 | Level interrupt |

## Verification
A match event and a software clear of the status bit can land on the same clock edge. The bench provokes this by starting a one-shot match a known number of cycles ahead. It then issues the clear write on exactly the edge that follows the cycle in which the counter equals the match value. The status bit must read as set afterwards, and a second clear must then take effect. A similar collision between a counter word write and a divider tick is judged by reading the written value back unchanged on the next cycle, then advancing from there.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;
  // word addresses
  localparam int unsigned ADR_CNT_LO = 0;
  localparam int unsigned ADR_CNT_HI = 1;
  localparam int unsigned ADR_CTRL   = 2;
  localparam int unsigned ADR_STAT   = 3;
  localparam int unsigned ADR_CMP_LO = 4;
  localparam int unsigned ADR_CMP_HI = 5;
  localparam int unsigned ADR_STEP   = 6;
  // control field positions
  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_CMP  = 1;
  localparam int unsigned CB_IEN  = 2;
  localparam int unsigned CB_AUTO = 3;
  localparam int unsigned CB_PS   = 8;
endpackage

// File: rtl/gtimer_divider.sv
module gtimer_divider #(
  parameter int unsigned PS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  logic [PS_W-1:0] div_q, div_d;

  assign tick = run && (div_q >= ps);

  always_comb begin
    if (!run)      div_d = '0;
    else if (tick) div_d = '0;
    else           div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/gtimer_counter.sv
module gtimer_counter #(
  parameter int unsigned BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [BUS_W-1:0]   wdata,
  output logic [2*BUS_W-1:0] cnt
);
  localparam int unsigned CW = 2 * BUS_W;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo)      cnt_d = {cnt_q[CW-1:BUS_W], wdata};
    else if (wr_hi) cnt_d = {wdata, cnt_q[BUS_W-1:0]};
    else if (tick)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/gtimer_match.sv
module gtimer_match #(
  parameter int unsigned BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*BUS_W-1:0] cnt,
  input  logic               cmp_en,
  input  logic               auto_en,
  input  logic [BUS_W-1:0]   step,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [BUS_W-1:0]   wdata,
  output logic [2*BUS_W-1:0] cmp,
  output logic               evt
);
  localparam int unsigned CW = 2 * BUS_W;
  logic [CW-1:0] cmp_q, cmp_d;
  logic          spent_q, spent_d;

  assign evt = cmp_en && !spent_q && (cnt >= cmp_q);

  always_comb begin
    cmp_d = cmp_q;
    if (wr_lo)               cmp_d = {cmp_q[CW-1:BUS_W], wdata};
    else if (wr_hi)          cmp_d = {wdata, cmp_q[BUS_W-1:0]};
    else if (evt && auto_en) cmp_d = cmp_q + {{BUS_W{1'b0}}, step};
  end

  always_comb begin
    spent_d = spent_q;
    if (wr_lo || wr_hi || !cmp_en) spent_d = 1'b0;
    else if (evt && !auto_en)      spent_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      spent_q <= 1'b0;
    end else begin
      cmp_q   <= cmp_d;
      spent_q <= spent_d;
    end
  end

  assign cmp = cmp_q;
endmodule

// File: rtl/gtimer_cmp.sv
module gtimer_cmp
  import gtimer_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned PS_W  = 8,
  parameter int unsigned AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wen,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq
);
  localparam int unsigned CW = 2 * BUS_W;

  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic wr_cnt_lo, wr_cnt_hi, wr_ctrl, wr_stat, wr_cmp_lo, wr_cmp_hi, wr_step;
  assign wr_cnt_lo = bus_wen && (bus_addr == AW'(ADR_CNT_LO));
  assign wr_cnt_hi = bus_wen && (bus_addr == AW'(ADR_CNT_HI));
  assign wr_ctrl   = bus_wen && (bus_addr == AW'(ADR_CTRL));
  assign wr_stat   = bus_wen && (bus_addr == AW'(ADR_STAT));
  assign wr_cmp_lo = bus_wen && (bus_addr == AW'(ADR_CMP_LO));
  assign wr_cmp_hi = bus_wen && (bus_addr == AW'(ADR_CMP_HI));
  assign wr_step   = bus_wen && (bus_addr == AW'(ADR_STEP));

  logic            run_q, cmp_en_q, ien_q, auto_q, flag_q;
  logic            run_d, cmp_en_d, ien_d, auto_d, flag_d;
  logic [PS_W-1:0] ps_q, ps_d;
  logic [BUS_W-1:0] step_q, step_d;
  logic            tick, evt;
  logic [CW-1:0]   cnt_q, cmp_q;

  always_comb begin
    run_d    = run_q;
    cmp_en_d = cmp_en_q;
    ien_d    = ien_q;
    auto_d   = auto_q;
    ps_d     = ps_q;
    if (wr_ctrl) begin
      run_d    = bus_wdata[CB_RUN];
      cmp_en_d = bus_wdata[CB_CMP];
      ien_d    = bus_wdata[CB_IEN];
      auto_d   = bus_wdata[CB_AUTO];
      ps_d     = bus_wdata[CB_PS +: PS_W];
    end
    step_d = wr_step ? bus_wdata : step_q;
    // a match event outranks a clear in the same cycle
    if (evt)                          flag_d = 1'b1;
    else if (wr_stat && bus_wdata[0]) flag_d = 1'b0;
    else                              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      run_q    <= 1'b0;
      cmp_en_q <= 1'b0;
      ien_q    <= 1'b0;
      auto_q   <= 1'b0;
      ps_q     <= '0;
      step_q   <= '0;
      flag_q   <= 1'b0;
    end else begin
      run_q    <= run_d;
      cmp_en_q <= cmp_en_d;
      ien_q    <= ien_d;
      auto_q   <= auto_d;
      ps_q     <= ps_d;
      step_q   <= step_d;
      flag_q   <= flag_d;
    end
  end

  gtimer_divider #(.PS_W(PS_W)) u_div (
    .clk(clk), .rst_n(rst_s_n), .run(run_q), .ps(ps_q), .tick(tick)
  );

  gtimer_counter #(.BUS_W(BUS_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .tick(tick), .wr_lo(wr_cnt_lo),
    .wr_hi(wr_cnt_hi), .wdata(bus_wdata), .cnt(cnt_q)
  );

  gtimer_match #(.BUS_W(BUS_W)) u_match (
    .clk(clk), .rst_n(rst_s_n), .cnt(cnt_q), .cmp_en(cmp_en_q),
    .auto_en(auto_q), .step(step_q), .wr_lo(wr_cmp_lo), .wr_hi(wr_cmp_hi),
    .wdata(bus_wdata), .cmp(cmp_q), .evt(evt)
  );

  logic [BUS_W-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd                = '0;
    ctrl_rd[CB_RUN]        = run_q;
    ctrl_rd[CB_CMP]        = cmp_en_q;
    ctrl_rd[CB_IEN]        = ien_q;
    ctrl_rd[CB_AUTO]       = auto_q;
    ctrl_rd[CB_PS +: PS_W] = ps_q;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(ADR_CNT_LO): bus_rdata = cnt_q[BUS_W-1:0];
      AW'(ADR_CNT_HI): bus_rdata = cnt_q[CW-1:BUS_W];
      AW'(ADR_CTRL):   bus_rdata = ctrl_rd;
      AW'(ADR_STAT):   bus_rdata = {{(BUS_W-1){1'b0}}, flag_q};
      AW'(ADR_CMP_LO): bus_rdata = cmp_q[BUS_W-1:0];
      AW'(ADR_CMP_HI): bus_rdata = cmp_q[CW-1:BUS_W];
      AW'(ADR_STEP):   bus_rdata = step_q;
      default:         bus_rdata = '0;
    endcase
  end

  assign irq = flag_q && ien_q;
endmodule

// File: rtl/gtimer_cmp_chk.sv
module gtimer_cmp_chk
  import gtimer_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned AW    = 3
) (
  input logic               clk,
  input logic               rst_s_n,
  input logic               bus_wen,
  input logic [AW-1:0]      bus_addr,
  input logic [BUS_W-1:0]   bus_wdata,
  input logic               run,
  input logic               cmp_en,
  input logic               auto_en,
  input logic               tick,
  input logic               evt,
  input logic               flag,
  input logic [BUS_W-1:0]   step,
  input logic [2*BUS_W-1:0] cnt,
  input logic [2*BUS_W-1:0] cmp
);
  logic cnt_wr, cmp_wr, ctrl_wr, clr_wr;
  assign cnt_wr  = bus_wen && (bus_addr == AW'(ADR_CNT_LO) || bus_addr == AW'(ADR_CNT_HI));
  assign cmp_wr  = bus_wen && (bus_addr == AW'(ADR_CMP_LO) || bus_addr == AW'(ADR_CMP_HI));
  assign ctrl_wr = bus_wen && (bus_addr == AW'(ADR_CTRL));
  assign clr_wr  = bus_wen && (bus_addr == AW'(ADR_STAT)) && bus_wdata[0];

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (tick && !cnt_wr) |=> cnt == $past(cnt) + 1'b1);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!run && !cnt_wr) |=> $stable(cnt));
  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    evt |=> flag);
  // R6
  oneshot_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (evt && !auto_en && !cmp_wr && !ctrl_wr) |=> !evt);
  // R7
  cmp_advance_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (evt && auto_en && !cmp_wr) |=> cmp == $past(cmp) + {{BUS_W{1'b0}}, $past(step)});
  // R8
  cmp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cmp_en && !cmp_wr) |=> $stable(cmp));
  // R8
  no_evt_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cmp_en |-> !evt);
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (flag && !clr_wr) |=> flag);
endmodule

bind gtimer_cmp gtimer_cmp_chk #(.BUS_W(BUS_W), .AW(AW)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .run(run_q), .cmp_en(cmp_en_q), .auto_en(auto_q),
  .tick(tick), .evt(evt), .flag(flag_q), .step(step_q), .cnt(cnt_q), .cmp(cmp_q)
);

// File: tb/gtimer_cmp_bench.sv
`timescale 1ns/1ps
module gtimer_cmp_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_wen;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  gtimer_cmp u_gtimer_cmp (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // called just after a falling edge; write lands on the next rising edge
  task automatic wr(input int a, input logic [31:0] d);
    bus_wen   = 1'b1;
    bus_addr  = 3'(a);
    bus_wdata = d;
    @(negedge clk);
    bus_wen   = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 3'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    bus_wen = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk($sformatf("R1 reset addr %0d", a), v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R4 control readback
    wr(2, 32'hFFFF_FFF0);
    rd(2, v); chk("R4 ctrl readback", v, 32'h0000_FF00);
    wr(2, 32'h0000_0000);
    rd(2, v); chk("R4 ctrl cleared", v, 32'h0);

    // R11 unused address
    wr(7, 32'hFFFF_FFFF);
    rd(7, v); chk("R11 unused reads zero", v, 32'h0);
    for (int a = 0; a < 7; a++) begin
      rd(a, v);
      chk($sformatf("R11 addr %0d untouched", a), v, 32'h0);
    end

    // R2 divider sweep
    for (int ps = 0; ps < 8; ps++) begin
      wr(2, 32'h0);
      wr(0, 32'h0);
      wr(1, 32'h0);
      wr(2, (32'(ps) << 8) | 32'h1);
      for (int k = 0; k < 25; k++) begin
        rd(0, v);
        chk($sformatf("R2 ps %0d cycle %0d", ps, k), v, 32'(k / (ps + 1)));
        @(negedge clk);
      end
      wr(2, (32'(ps) << 8));
      rd(0, v);
      repeat (5) @(negedge clk);
      begin
        logic [31:0] v2;
        rd(0, v2);
        chk($sformatf("R2 hold ps %0d", ps), v2, v);
      end
    end

    // R3 carry and write override
    wr(2, 32'h0);
    wr(0, 32'hFFFF_FFFE);
    wr(1, 32'h1234_5678);
    wr(2, 32'h1);
    repeat (3) @(negedge clk);
    rd(0, v); chk("R3 carry low", v, 32'h1);
    rd(1, v); chk("R3 carry high", v, 32'h1234_5679);
    wr(0, 32'd100);
    rd(0, v); chk("R3 write beats tick", v, 32'd100);
    repeat (2) @(negedge clk);
    rd(0, v); chk("R3 advance after write", v, 32'd102);

    // R7 periodic sweep
    wr(2, 32'h0);
    wr(0, 32'h0); wr(1, 32'h0);
    wr(4, 32'd5); wr(5, 32'h0);
    wr(6, 32'd7);
    wr(3, 32'h1);
    wr(2, 32'h0000_000B);
    for (int k = 0; k < 41; k++) begin
      int n;
      n = (k >= 6) ? ((k - 6) / 7 + 1) : 0;
      rd(4, v); chk($sformatf("R7 match at cycle %0d", k), v, 32'(5 + 7 * n));
      rd(0, v); chk($sformatf("R7 count at cycle %0d", k), v, 32'(k));
      if (k == 5 || k == 6) begin
        rd(3, v); chk($sformatf("R5 flag at cycle %0d", k), v, (k == 6) ? 32'h1 : 32'h0);
      end
      @(negedge clk);
    end

    // R5 one-shot timing, R6, R9 collision, R10
    wr(2, 32'h0);
    wr(0, 32'h0); wr(1, 32'h0);
    wr(4, 32'd10); wr(5, 32'h0);
    wr(3, 32'h1);
    wr(2, 32'h0000_0007);
    repeat (10) @(negedge clk);
    rd(3, v); chk("R5 no flag at match cycle", v, 32'h0);
    @(negedge clk);
    rd(3, v); chk("R5 flag one edge later", v, 32'h1);
    chk("R10 irq with enable", {31'b0, irq}, 32'h1);
    wr(3, 32'h0);
    rd(3, v); chk("R9 write zero ignored", v, 32'h1);
    wr(3, 32'h1);
    rd(3, v); chk("R9 write one clears", v, 32'h0);
    repeat (6) @(negedge clk);
    rd(3, v); chk("R6 no refire one-shot", v, 32'h0);
    chk("R10 irq low when clear", {31'b0, irq}, 32'h0);

    // R9 set and clear in same cycle
    wr(2, 32'h0);
    wr(0, 32'h0); wr(1, 32'h0);
    wr(4, 32'd3); wr(5, 32'h0);
    wr(3, 32'h1);
    wr(2, 32'h0000_0007);
    repeat (3) @(negedge clk);
    wr(3, 32'h1);
    rd(3, v); chk("R9 set wins over clear", v, 32'h1);
    wr(3, 32'h1);
    rd(3, v); chk("R9 later clear works", v, 32'h0);

    // R6 rearm by match write, R10 gating
    wr(2, 32'h0000_0003);
    wr(4, 32'h0);
    @(negedge clk);
    rd(3, v); chk("R6 rearm after match write", v, 32'h1);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    wr(2, 32'h0000_0007);
    chk("R10 irq unmasked", {31'b0, irq}, 32'h1);

    // R8 compare disabled
    wr(2, 32'h0);
    wr(0, 32'h0); wr(1, 32'h0);
    wr(4, 32'd2); wr(5, 32'h0);
    wr(6, 32'd1);
    wr(3, 32'h1);
    wr(2, 32'h0000_000D);
    repeat (10) @(negedge clk);
    rd(0, v); chk("R8 counter runs", v, 32'd10);
    rd(4, v); chk("R8 match unchanged", v, 32'd2);
    rd(3, v); chk("R8 no flag", v, 32'h0);
    chk("R8 no irq", {31'b0, irq}, 32'h0);

    finish_run();
  end
endmodule